// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Output Latency Select

This block is a true two-port synchronous memory. A left port and a right port, each with its own clock, can both read or write any word at the same time. Every port captures its address, its two chip selects, its read/write control, its byte-lane selects and its write data on the rising edge of its own clock. A word is split into byte lanes. The default is two lanes of 9 bits, so a word is 18 bits. Each lane can be written or driven out on its own.

A static mode input on each port sets the read latency. In flow-through mode, data for an address captured on one edge is presented right after that edge. In pipelined mode, the data passes through one more output register and appears one clock later. The outputs for each cycle are set by the controls captured in the cycle before. A write or a deselected cycle therefore leaves the data lanes undriven in its output slot.

An asynchronous active-low output enable gates the lane drivers with no clock. The high-impedance state is shown as a per-lane drive flag, and the data bits of an undriven lane are held at zero. Depth and lane geometry are parameters. The default depth is 1024 words.

Top module: `dpram_dual_sync`

## Requirements
- R1: A port is selected at an edge only when its active-low select `cs_n` is 0 and its active-high select `cs` is 1 at that edge. An edge without selection writes nothing, and its output slot drives no lane.
- R2: `wr_n` = 0 at a selected edge writes the word; `wr_n` = 1 reads it. A read returns the value last written to that address.
- R3: With `pipe` = 0, read data for an address captured at edge N is on `q` and both drive flags are set from just after edge N until edge N+1.
- R4: With `pipe` = 1, the same data appears just after edge N+1. The slot just after edge N shows the previous cycle's state, which is undriven when that cycle was idle.
- R5: `bsel_n[0]` = 0 enables lane 0 (bits 8:0) and `bsel_n[1]` = 0 enables lane 1 (bits 17:9). A write changes only the enabled lanes. A write with both lanes disabled changes nothing.
- R6: A read drives lane k (`drv[k]` = 1) only if `bsel_n[k]` was 0 at the read edge and `oe_n` is 0. An undriven lane reads as zero on `q`.
- R7: `oe_n` = 1 clears all drive flags and zeroes `q` immediately, with no clock. Returning `oe_n` to 0 restores the pending read data immediately.
- R8: A write cycle drives no lane in its output slot. In pipelined mode, read A, write B, read C yields A, then an undriven turnaround slot, then C.
- R9: A word written by one port is returned by a read on the other port at any later edge. Reads on one port run alongside writes on the other.
- R10: After reset, both ports drive no lane until a read has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| clk_r | input | 1 | Right port clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output control stages |
| cs_n_l | input | 1 | Left active-low chip select |
| cs_l | input | 1 | Left active-high chip select |
| wr_n_l | input | 1 | Left write (0) / read (1) |
| bsel_n_l | input | LANES | Left active-low byte-lane selects, bit k for lane k |
| oe_n_l | input | 1 | Left asynchronous active-low output enable |
| pipe_l | input | 1 | Left latency mode: 0 flow-through, 1 pipelined |
| addr_l | input | log2(DEPTH) | Left word address |
| wdata_l | input | LANES*LANE_W | Left write data |
| q_l | output | LANES*LANE_W | Left read data, undriven lanes zero |
| drv_l | output | LANES | Left per-lane drive flag (0 = high impedance) |
| cs_n_r | input | 1 | Right active-low chip select |
| cs_r | input | 1 | Right active-high chip select |
| wr_n_r | input | 1 | Right write (0) / read (1) |
| bsel_n_r | input | LANES | Right active-low byte-lane selects |
| oe_n_r | input | 1 | Right asynchronous active-low output enable |
| pipe_r | input | 1 | Right latency mode: 0 flow-through, 1 pipelined |
| addr_r | input | log2(DEPTH) | Right word address |
| wdata_r | input | LANES*LANE_W | Right write data |
| q_r | output | LANES*LANE_W | Right read data, undriven lanes zero |
| drv_r | output | LANES | Right per-lane drive flag |

## Verification
The bench changes inputs on the falling edge and samples outputs on the falling edge that follows the edge under test:
- In flow-through mode, data from a read captured at edge N is checked half a cycle after edge N.
- In pipelined mode, the same read is checked half a cycle after edge N+1, and the slot before it is checked to be undriven.
- Turnaround and deselect slots are checked in the same output slot that a read would have used.

The output-enable checks toggle `oe_n` between two edges. They sample after a sub-cycle delay, which shows that the drive flags respond with no clock. Full-depth sweeps on a 16-word build compare every word with a model held in the bench. That model is updated for each lane-masked write.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;

   typedef enum logic {
      MODE_FLOW = 1'b0,
      MODE_PIPE = 1'b1
   } out_mode_e;

   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/dpram_xor_store.sv
`timescale 1ns/1ps
// Two banks, each written only from its own clock domain; a word is the XOR of both.
module dpram_xor_store #(
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 9,
   localparam int unsigned W  = LANES * LANE_W,
   localparam int unsigned AW = dpram_pkg::addr_bits(DEPTH)
) (
   input  logic             clk_a,
   input  logic             en_a,
   input  logic             we_a,
   input  logic [LANES-1:0] lane_a,
   input  logic [AW-1:0]    addr_a,
   input  logic [W-1:0]     wd_a,
   output logic [W-1:0]     rd_a,
   input  logic             clk_b,
   input  logic             en_b,
   input  logic             we_b,
   input  logic [LANES-1:0] lane_b,
   input  logic [AW-1:0]    addr_b,
   input  logic [W-1:0]     wd_b,
   output logic [W-1:0]     rd_b
);

   logic [W-1:0] bank_a [DEPTH];
   logic [W-1:0] bank_b [DEPTH];

   // port A: store data XOR the other bank so that the XOR of both yields data
   always_ff @(posedge clk_a) begin
      if (en_a) begin
         if (we_a) begin
            for (int k = 0; k < LANES; k++) begin
               if (lane_a[k]) begin
                  bank_a[addr_a][k*LANE_W +: LANE_W] <=
                     wd_a[k*LANE_W +: LANE_W] ^ bank_b[addr_a][k*LANE_W +: LANE_W];
               end
            end
         end else begin
            rd_a <= bank_a[addr_a] ^ bank_b[addr_a];
         end
      end
   end

   always_ff @(posedge clk_b) begin
      if (en_b) begin
         if (we_b) begin
            for (int k = 0; k < LANES; k++) begin
               if (lane_b[k]) begin
                  bank_b[addr_b][k*LANE_W +: LANE_W] <=
                     wd_b[k*LANE_W +: LANE_W] ^ bank_a[addr_b][k*LANE_W +: LANE_W];
               end
            end
         end else begin
            rd_b <= bank_a[addr_b] ^ bank_b[addr_b];
         end
      end
   end

endmodule

// File: rtl/dpram_port_ctl.sv
`timescale 1ns/1ps
// Per-port control decode, optional second output stage and lane drive gating.
module dpram_port_ctl #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 9,
   localparam int unsigned W = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             cs,
   input  logic             wr_n,
   input  logic [LANES-1:0] bsel_n,
   input  logic             oe_n,
   input  logic             pipe,
   input  logic [W-1:0]     arr_rd,
   output logic             sel,
   output logic             we,
   output logic [LANES-1:0] lane,
   output logic [W-1:0]     q,
   output logic [LANES-1:0] drv
);
   import dpram_pkg::*;

   out_mode_e        mode;
   logic             rd_s1, rd_s2;
   logic [LANES-1:0] ln_s1, ln_s2;
   logic [W-1:0]     q_s2;
   logic             rd_o;
   logic [LANES-1:0] ln_o;
   logic [W-1:0]     q_o;

   assign sel  = ~cs_n & cs;
   assign we   = ~wr_n;
   assign lane = ~bsel_n;
   assign mode = out_mode_e'(pipe);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_s1 <= 1'b0;
         rd_s2 <= 1'b0;
         ln_s1 <= '0;
         ln_s2 <= '0;
      end else begin
         rd_s1 <= sel & ~we;
         ln_s1 <= lane;
         rd_s2 <= rd_s1;
         ln_s2 <= ln_s1;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_s1) q_s2 <= arr_rd;
   end

   always_comb begin
      if (mode == MODE_PIPE) begin
         rd_o = rd_s2;
         ln_o = ln_s2;
         q_o  = q_s2;
      end else begin
         rd_o = rd_s1;
         ln_o = ln_s1;
         q_o  = arr_rd;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign drv[g] = rd_o & ln_o[g] & ~oe_n;
      assign q[g*LANE_W +: LANE_W] = drv[g] ? q_o[g*LANE_W +: LANE_W] : '0;
   end

   assert_desel_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((cs_n || !cs) && !pipe) |=> (pipe || drv == '0));

   assert_flow_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe && !cs_n && cs && wr_n && !bsel_n[0]) |=> (pipe || oe_n || drv[0]));

   assert_pipe_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe && !cs_n && cs && wr_n && !bsel_n[0]) |-> ##2 (!pipe || oe_n || drv[0]));

   assert_lane_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe && bsel_n[LANES-1]) |=> (pipe || !drv[LANES-1]));

   assert_write_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && !pipe) |=> (pipe || drv == '0));

   assert_pipe_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && pipe) |-> ##2 (!pipe || drv == '0));

endmodule

// File: rtl/dpram_dual_sync.sv
`timescale 1ns/1ps
module dpram_dual_sync #(
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 9,
   localparam int unsigned W  = LANES * LANE_W,
   localparam int unsigned AW = dpram_pkg::addr_bits(DEPTH)
) (
   input  logic             clk_l,
   input  logic             clk_r,
   input  logic             rst_n,
   input  logic             cs_n_l,
   input  logic             cs_l,
   input  logic             wr_n_l,
   input  logic [LANES-1:0] bsel_n_l,
   input  logic             oe_n_l,
   input  logic             pipe_l,
   input  logic [AW-1:0]    addr_l,
   input  logic [W-1:0]     wdata_l,
   output logic [W-1:0]     q_l,
   output logic [LANES-1:0] drv_l,
   input  logic             cs_n_r,
   input  logic             cs_r,
   input  logic             wr_n_r,
   input  logic [LANES-1:0] bsel_n_r,
   input  logic             oe_n_r,
   input  logic             pipe_r,
   input  logic [AW-1:0]    addr_r,
   input  logic [W-1:0]     wdata_r,
   output logic [W-1:0]     q_r,
   output logic [LANES-1:0] drv_r
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("LANE_W must be at least 1");
   end

   logic             sel_l, we_l, sel_r, we_r;
   logic [LANES-1:0] lane_l, lane_r;
   logic [W-1:0]     ard_l, ard_r;

   dpram_port_ctl #(.LANES(LANES), .LANE_W(LANE_W)) u_ctl_l (
      .clk(clk_l), .rst_n(rst_n), .cs_n(cs_n_l), .cs(cs_l), .wr_n(wr_n_l),
      .bsel_n(bsel_n_l), .oe_n(oe_n_l), .pipe(pipe_l), .arr_rd(ard_l),
      .sel(sel_l), .we(we_l), .lane(lane_l), .q(q_l), .drv(drv_l)
   );

   dpram_port_ctl #(.LANES(LANES), .LANE_W(LANE_W)) u_ctl_r (
      .clk(clk_r), .rst_n(rst_n), .cs_n(cs_n_r), .cs(cs_r), .wr_n(wr_n_r),
      .bsel_n(bsel_n_r), .oe_n(oe_n_r), .pipe(pipe_r), .arr_rd(ard_r),
      .sel(sel_r), .we(we_r), .lane(lane_r), .q(q_r), .drv(drv_r)
   );

   dpram_xor_store #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk_a(clk_l), .en_a(sel_l), .we_a(we_l), .lane_a(lane_l),
      .addr_a(addr_l), .wd_a(wdata_l), .rd_a(ard_l),
      .clk_b(clk_r), .en_b(sel_r), .we_b(we_r), .lane_b(lane_r),
      .addr_b(addr_r), .wd_b(wdata_r), .rd_b(ard_r)
   );

endmodule

// File: tb/tb_dpram_dual_sync.sv
`timescale 1ns/1ps
module tb_dpram_dual_sync;

   localparam int N = 16;

   logic clk = 1'b0;
   logic rst_n;
   logic cs_n_l, cs_l, wr_n_l, oe_n_l, pipe_l;
   logic cs_n_r, cs_r, wr_n_r, oe_n_r, pipe_r;
   logic [1:0]  bsel_n_l, bsel_n_r, drv_l, drv_r;
   logic [3:0]  addr_l, addr_r;
   logic [17:0] wdata_l, wdata_r, q_l, q_r;

   logic [17:0] mdl [N];
   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dpram_dual_sync #(.DEPTH(N), .LANES(2), .LANE_W(9)) dut (
      .clk_l(clk), .clk_r(clk), .rst_n(rst_n),
      .cs_n_l(cs_n_l), .cs_l(cs_l), .wr_n_l(wr_n_l), .bsel_n_l(bsel_n_l),
      .oe_n_l(oe_n_l), .pipe_l(pipe_l), .addr_l(addr_l), .wdata_l(wdata_l),
      .q_l(q_l), .drv_l(drv_l),
      .cs_n_r(cs_n_r), .cs_r(cs_r), .wr_n_r(wr_n_r), .bsel_n_r(bsel_n_r),
      .oe_n_r(oe_n_r), .pipe_r(pipe_r), .addr_r(addr_r), .wdata_r(wdata_r),
      .q_r(q_r), .drv_r(drv_r)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_p(input int p, input logic csn, input logic cs, input logic wrn,
                        input logic [1:0] bn, input int a, input logic [17:0] d);
      if (p == 0) begin
         cs_n_l = csn; cs_l = cs; wr_n_l = wrn; bsel_n_l = bn;
         addr_l = 4'(a); wdata_l = d;
      end else begin
         cs_n_r = csn; cs_r = cs; wr_n_r = wrn; bsel_n_r = bn;
         addr_r = 4'(a); wdata_r = d;
      end
   endtask

   task automatic idle_p(input int p);
      set_p(p, 1'b1, 1'b1, 1'b1, 2'b11, 0, 18'h0);
   endtask

   function automatic logic [17:0] get_q(input int p);
      return (p == 0) ? q_l : q_r;
   endfunction

   function automatic logic [1:0] get_drv(input int p);
      return (p == 0) ? drv_l : drv_r;
   endfunction

   // write full words, one per cycle, then idle
   task automatic wr_seq(input int p, input int first, input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         int a;
         logic [17:0] v;
         a = (first + i) % N;
         v = 18'((a * 12345 + seed * 977 + 7) & 32'h3FFFF);
         @(negedge clk);
         set_p(p, 1'b0, 1'b1, 1'b0, 2'b00, a, v);
         mdl[a] = v;
      end
      @(negedge clk);
      idle_p(p);
   endtask

   // back-to-back full-lane reads; caller leaves the port idle beforehand
   task automatic rd_stream(input int p, input int first, input int n, input string req);
      int lat;
      lat = ((p == 0) ? pipe_l : pipe_r) ? 2 : 1;
      for (int i = 0; i < n + lat; i++) begin
         @(negedge clk);
         if (i >= lat) begin
            chk(req, "read data", 32'(get_q(p)), 32'(mdl[(first + i - lat) % N]));
            chk(req, "drive flags", 32'(get_drv(p)), 32'h3);
         end else if (lat == 2 && i == 1) begin
            chk(req, "empty pipe slot", 32'(get_drv(p)), 32'h0);
         end
         if (i < n) set_p(p, 1'b0, 1'b1, 1'b1, 2'b00, (first + i) % N, 18'h0);
         else idle_p(p);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      oe_n_l = 1'b0; oe_n_r = 1'b0;
      pipe_l = 1'b0; pipe_r = 1'b0;
      idle_p(0);
      idle_p(1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "left drive after reset", 32'(drv_l), 32'h0);
      chk("R10", "right drive after reset", 32'(drv_r), 32'h0);

      // R2 R3: left fills, left reads in flow-through mode
      wr_seq(0, 0, N, 1);
      rd_stream(0, 0, N, "R2 R3");
      // R9: right reads words written by the left
      rd_stream(1, 0, N, "R9");
      // R4 R9: right rewrites all, left reads pipelined
      wr_seq(1, 0, N, 2);
      pipe_l = 1'b1;
      rd_stream(0, 0, N, "R4 R9");
      pipe_l = 1'b0;

      // R5: lane-masked writes
      @(negedge clk);
      set_p(0, 1'b0, 1'b1, 1'b0, 2'b10, 3, 18'h3FFFF);
      mdl[3][8:0] = 9'h1FF;
      @(negedge clk);
      set_p(0, 1'b0, 1'b1, 1'b0, 2'b01, 4, 18'h0);
      mdl[4][17:9] = 9'h0;
      @(negedge clk);
      set_p(0, 1'b0, 1'b1, 1'b0, 2'b11, 5, 18'h15555);
      @(negedge clk);
      idle_p(0);
      rd_stream(0, 3, 3, "R5");

      // R6: partial lane reads
      @(negedge clk);
      set_p(0, 1'b0, 1'b1, 1'b1, 2'b10, 3, 18'h0);
      @(negedge clk);
      chk("R6", "lower-only drive", 32'(drv_l), 32'h1);
      chk("R6", "lower-only data", 32'(q_l), 32'({9'h0, mdl[3][8:0]}));
      set_p(0, 1'b0, 1'b1, 1'b1, 2'b01, 3, 18'h0);
      @(negedge clk);
      chk("R6", "upper-only drive", 32'(drv_l), 32'h2);
      chk("R6", "upper-only data", 32'(q_l), 32'({mdl[3][17:9], 9'h0}));
      idle_p(0);

      // R7: asynchronous output enable
      @(negedge clk);
      set_p(0, 1'b0, 1'b1, 1'b1, 2'b00, 7, 18'h0);
      @(negedge clk);
      chk("R7", "drive before oe off", 32'(drv_l), 32'h3);
      oe_n_l = 1'b1;
      #0.5;
      chk("R7", "drive with oe off", 32'(drv_l), 32'h0);
      chk("R7", "data with oe off", 32'(q_l), 32'h0);
      oe_n_l = 1'b0;
      #0.5;
      chk("R7", "data after oe back", 32'(q_l), 32'(mdl[7]));
      idle_p(0);

      // R1: deselected writes and reads
      @(negedge clk);
      set_p(0, 1'b1, 1'b1, 1'b0, 2'b00, 8, ~mdl[8]);
      @(negedge clk);
      set_p(0, 1'b0, 1'b0, 1'b0, 2'b00, 9, ~mdl[9]);
      @(negedge clk);
      set_p(0, 1'b0, 1'b0, 1'b1, 2'b00, 8, 18'h0);
      @(negedge clk);
      chk("R1", "deselected read drive", 32'(drv_l), 32'h0);
      idle_p(0);
      rd_stream(0, 8, 2, "R1");

      // R8: pipelined read-write-read turnaround
      @(negedge clk);
      pipe_l = 1'b1;
      @(negedge clk);
      set_p(0, 1'b0, 1'b1, 1'b1, 2'b00, 10, 18'h0);
      @(negedge clk);
      set_p(0, 1'b0, 1'b1, 1'b0, 2'b00, 11, 18'h2B3C4);
      mdl[11] = 18'h2B3C4;
      @(negedge clk);
      chk("R8", "pipe first read", 32'(q_l), 32'(mdl[10]));
      set_p(0, 1'b0, 1'b1, 1'b1, 2'b00, 12, 18'h0);
      @(negedge clk);
      chk("R8", "pipe turnaround slot", 32'(drv_l), 32'h0);
      idle_p(0);
      @(negedge clk);
      chk("R8", "pipe read after write", 32'(q_l), 32'(mdl[12]));
      pipe_l = 1'b0;
      // flow-through write slot
      @(negedge clk);
      set_p(0, 1'b0, 1'b1, 1'b0, 2'b00, 13, 18'h0F0F0);
      mdl[13] = 18'h0F0F0;
      @(negedge clk);
      chk("R8", "flow write slot", 32'(drv_l), 32'h0);
      set_p(0, 1'b0, 1'b1, 1'b1, 2'b00, 11, 18'h0);
      @(negedge clk);
      chk("R8", "flow read of written word", 32'(q_l), 32'(mdl[11]));
      idle_p(0);

      // R9: concurrent write on left, read on right
      @(negedge clk);
      set_p(0, 1'b0, 1'b1, 1'b0, 2'b00, 14, 18'h3A5A5);
      set_p(1, 1'b0, 1'b1, 1'b1, 2'b00, 15, 18'h0);
      @(negedge clk);
      chk("R9", "right read during left write", 32'(q_r), 32'(mdl[15]));
      mdl[14] = 18'h3A5A5;
      idle_p(0);
      set_p(1, 1'b0, 1'b1, 1'b1, 2'b00, 14, 18'h0);
      @(negedge clk);
      chk("R9", "right sees left write", 32'(q_r), 32'(mdl[14]));
      idle_p(1);
      rd_stream(1, 13, 2, "R9");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule